// File: doc/BRIEF.md
# Bit-Serial Tree Arbitration Engine

This block runs one tag's part of a deterministic anticollision or group-selection round. When a round starts, it picks a start position in a bit-addressable memory. It then walks that memory one bit at a time, from the high address toward lower addresses, and offers each bit to the modulator. For every bit it takes in the bit the reader returns. The first bits of a round form a preamble. The tag sends them, but they take no part in the contest.

After the preamble, the engine compares the tag's field with the reader's stream, most significant bit first. It can compare for equality, for less-or-equal, or for greater-or-equal. The first bit where the two streams differ settles the outcome for the rest of the round. A tag that drops out stops driving the modulator. It keeps counting the reader's bits, so it still sees the end of the frame at the right moment.

When the round ends, the outcome updates the persistent selection flags. An anticollision round marks the tag either as a winner or as a loser. A group-selection round rewrites the group membership flag. A reset command from the reader clears the two anticollision flags.

Top module: `tree_arbiter`

## Requirements
- R1: After the asynchronous reset, busy_o, done_o, tx_en_o, won_o, id_o, ids_o and presel_o are all 0.
- R2: A start_i pulse loads the first memory address, visible on mem_addr_o one cycle later. The address is ptr_i when ptr_en_i is 1. Otherwise it is 103 when blk_sel_i is 0, and 71 when blk_sel_i is 1.
- R3: Each rsp_vld_i accepted while busy moves mem_addr_o down by one, wrapping from 0 to MEM_BITS-1 (255 by default).
- R4: tx_bit_o always equals the memory bit at mem_addr_o. tx_en_o is 1 only while busy and still in contention.
- R5: The first PRE_LEN (8) reader bits of a round do not affect the outcome, and tx_en_o stays 1 through them.
- R6: mode_i = 0 (and the spare code 3) means equality. The tag leaves contention at the first bit where its field differs from the reader's stream.
- R7: mode_i = 1 means less-or-equal, compared MSB first. The tag stays in contention only while its field read so far is no greater than the reader's bits so far. Once a difference has made it smaller, later bits cannot remove it.
- R8: mode_i = 2 means greater-or-equal, with the same MSB-first rule mirrored.
- R9: A round lasts exactly PRE_LEN+len_i reader bits, whether or not the tag has dropped out. One cycle after the last bit, done_o pulses for one cycle, busy_o is 0, and won_o shows the outcome.
- R10: In a round with kind_i = 0 (anticollision), a win sets id_o and a loss sets ids_o. The other flag is left as it was.
- R11: In a round with kind_i = 1 (group selection), presel_o takes the outcome: set on a win, cleared on a loss.
- R12: A cmd_reset_i pulse clears id_o and ids_o on the next edge and leaves presel_o unchanged.
- R13: rsp_vld_i while idle has no effect: mem_addr_o, done_o and all flags stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that begins a round using the settings below |
| kind_i | input | 1 | 0 = anticollision round, 1 = group-selection round |
| mode_i | input | 2 | Comparison: 0 equal, 1 less-or-equal, 2 greater-or-equal, 3 equal |
| blk_sel_i | input | 1 | Chooses between the two fixed start positions |
| ptr_en_i | input | 1 | Use ptr_i as the start position |
| ptr_i | input | AW (8) | Programmable start bit address |
| len_i | input | LEN_W (8) | Number of compared bits after the preamble |
| rsp_vld_i | input | 1 | Strobe: one reader bit present |
| rsp_bit_i | input | 1 | Reader bit for the current position |
| cmd_reset_i | input | 1 | Reader reset command pulse |
| mem_addr_o | output | AW (8) | Bit address to the memory read port |
| mem_bit_i | input | 1 | Memory bit at mem_addr_o, same cycle |
| tx_en_o | output | 1 | Drive the modulator this bit |
| tx_bit_o | output | 1 | Bit to send back |
| busy_o | output | 1 | Round in progress |
| done_o | output | 1 | One-cycle pulse at round end |
| won_o | output | 1 | Outcome of the last round |
| id_o | output | 1 | Anticollision win flag |
| ids_o | output | 1 | Anticollision loss flag |
| presel_o | output | 1 | Group membership flag |

## Verification
Rounds with a matching field and with a single mismatch in the middle separate the equality mode from the ordered modes. The drop of tx_en_o must land on the mismatching bit, and the bit count must carry on to the frame end. For the ordered modes, some reader streams first differ in the tag's favour and then turn against it in the lower bits; these show that the first difference really freezes the result. A tie in greater-or-equal mode and a one-bit mismatch in the spare mode code cover the boundaries. Preamble bits are inverted against the tag, so any comparison during the preamble would show up as a loss. A start pointer near address 0 exercises the wrap, and strobes while idle confirm that nothing moves.

// File: rtl/tarb_pkg.sv
package tarb_pkg;

  typedef enum logic [1:0] {
    CMP_EQ  = 2'd0,
    CMP_LE  = 2'd1,
    CMP_GE  = 2'd2,
    CMP_EQ2 = 2'd3
  } cmp_mode_e;

  // Ordering of the tag field relative to the reader stream so far.
  typedef enum logic [1:0] {
    REL_SAME = 2'd0,
    REL_LESS = 2'd1,
    REL_MORE = 2'd2
  } rel_e;

  function automatic logic still_in(cmp_mode_e m, rel_e r);
    case (m)
      CMP_LE:  return (r != REL_MORE);
      CMP_GE:  return (r != REL_LESS);
      default: return (r == REL_SAME);
    endcase
  endfunction

endpackage

// File: rtl/tarb_walker.sv
module tarb_walker #(
  parameter int AW        = 8,
  parameter int CW        = 9,
  parameter int PRE_LEN   = 8,
  parameter int DEF_START = 103,
  parameter int ALT_START = 71
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          blk_sel_i,
  input  logic          ptr_en_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [CW-1:0] len_i,
  input  logic          step_i,
  output logic          busy_o,
  output logic [AW-1:0] addr_o,
  output logic          cmp_phase_o,
  output logic          finish_o
);

  logic          busy_q, busy_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] idx_q, idx_d;
  logic [CW-1:0] total_q, total_d;
  logic          last_bit;

  always_comb begin
    busy_d   = busy_q;
    addr_d   = addr_q;
    idx_d    = idx_q;
    total_d  = total_q;
    last_bit = busy_q && step_i && ((idx_q + CW'(1)) == total_q);
    if (start_i) begin
      busy_d  = 1'b1;
      idx_d   = '0;
      total_d = CW'(PRE_LEN) + len_i;
      if (ptr_en_i)       addr_d = ptr_i;
      else if (blk_sel_i) addr_d = AW'(ALT_START);
      else                addr_d = AW'(DEF_START);
    end else if (busy_q && step_i) begin
      addr_d = addr_q - AW'(1);
      idx_d  = idx_q + CW'(1);
      if (last_bit) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      addr_q  <= '0;
      idx_q   <= '0;
      total_q <= '0;
    end else begin
      busy_q  <= busy_d;
      addr_q  <= addr_d;
      idx_q   <= idx_d;
      total_q <= total_d;
    end
  end

  assign busy_o      = busy_q;
  assign addr_o      = addr_q;
  assign cmp_phase_o = (idx_q >= CW'(PRE_LEN));
  assign finish_o    = last_bit && !start_i;

endmodule

// File: rtl/tarb_cmp.sv
module tarb_cmp
  import tarb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear_i,
  input  cmp_mode_e mode_i,
  input  logic      step_i,
  input  logic      tag_bit_i,
  input  logic      rdr_bit_i,
  output logic      alive_o,
  output logic      alive_nxt_o
);

  cmp_mode_e mode_q, mode_d;
  rel_e      rel_q, rel_d;

  always_comb begin
    mode_d = mode_q;
    rel_d  = rel_q;
    if (clear_i) begin
      mode_d = mode_i;
      rel_d  = REL_SAME;
    end else if (step_i && (rel_q == REL_SAME) && (tag_bit_i != rdr_bit_i)) begin
      rel_d = tag_bit_i ? REL_MORE : REL_LESS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= CMP_EQ;
      rel_q  <= REL_SAME;
    end else begin
      mode_q <= mode_d;
      rel_q  <= rel_d;
    end
  end

  assign alive_o     = still_in(mode_q, rel_q);
  assign alive_nxt_o = still_in(mode_q, rel_d);

endmodule

// File: rtl/tarb_flags.sv
module tarb_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic kind_i,
  input  logic finish_i,
  input  logic won_i,
  input  logic cmd_reset_i,
  output logic id_o,
  output logic ids_o,
  output logic presel_o
);

  logic kind_q, kind_d;
  logic id_q, id_d;
  logic ids_q, ids_d;
  logic pre_q, pre_d;

  always_comb begin
    kind_d = start_i ? kind_i : kind_q;
    id_d   = id_q;
    ids_d  = ids_q;
    pre_d  = pre_q;
    if (finish_i) begin
      if (kind_q) pre_d = won_i;
      else if (won_i) id_d = 1'b1;
      else ids_d = 1'b1;
    end
    if (cmd_reset_i) begin
      id_d  = 1'b0;
      ids_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= 1'b0;
      id_q   <= 1'b0;
      ids_q  <= 1'b0;
      pre_q  <= 1'b0;
    end else begin
      kind_q <= kind_d;
      id_q   <= id_d;
      ids_q  <= ids_d;
      pre_q  <= pre_d;
    end
  end

  assign id_o     = id_q;
  assign ids_o    = ids_q;
  assign presel_o = pre_q;

endmodule

// File: rtl/tree_arbiter.sv
module tree_arbiter
  import tarb_pkg::*;
#(
  parameter int MEM_BITS  = 256,
  parameter int LEN_W     = 8,
  parameter int PRE_LEN   = 8,
  parameter int DEF_START = 103,
  parameter int ALT_START = 71,
  localparam int AW       = $clog2(MEM_BITS),
  localparam int CW       = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             kind_i,
  input  logic [1:0]       mode_i,
  input  logic             blk_sel_i,
  input  logic             ptr_en_i,
  input  logic [AW-1:0]    ptr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             rsp_vld_i,
  input  logic             rsp_bit_i,
  input  logic             cmd_reset_i,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_bit_i,
  output logic             tx_en_o,
  output logic             tx_bit_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             won_o,
  output logic             id_o,
  output logic             ids_o,
  output logic             presel_o
);

  logic busy, cmp_phase, finish;
  logic alive, alive_nxt, cmp_step;
  logic done_q, done_d, won_q, won_d;

  tarb_walker #(
    .AW(AW), .CW(CW), .PRE_LEN(PRE_LEN),
    .DEF_START(DEF_START), .ALT_START(ALT_START)
  ) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .blk_sel_i   (blk_sel_i),
    .ptr_en_i    (ptr_en_i),
    .ptr_i       (ptr_i),
    .len_i       (CW'(len_i)),
    .step_i      (rsp_vld_i),
    .busy_o      (busy),
    .addr_o      (mem_addr_o),
    .cmp_phase_o (cmp_phase),
    .finish_o    (finish)
  );

  assign cmp_step = busy && rsp_vld_i && cmp_phase && !start_i;

  tarb_cmp u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (start_i),
    .mode_i      (cmp_mode_e'(mode_i)),
    .step_i      (cmp_step),
    .tag_bit_i   (mem_bit_i),
    .rdr_bit_i   (rsp_bit_i),
    .alive_o     (alive),
    .alive_nxt_o (alive_nxt)
  );

  tarb_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .kind_i      (kind_i),
    .finish_i    (finish),
    .won_i       (alive_nxt),
    .cmd_reset_i (cmd_reset_i),
    .id_o        (id_o),
    .ids_o       (ids_o),
    .presel_o    (presel_o)
  );

  always_comb begin
    done_d = finish;
    won_d  = finish ? alive_nxt : won_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      won_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      won_q  <= won_d;
    end
  end

  assign busy_o   = busy;
  assign done_o   = done_q;
  assign won_o    = won_q;
  assign tx_bit_o = mem_bit_i;
  assign tx_en_o  = busy && alive;

endmodule

// File: rtl/tree_arbiter_chk.sv
module tree_arbiter_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          rsp_vld_i,
  input logic          cmd_reset_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          tx_en_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          id_o,
  input logic          ids_o
);

  AST_TX_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_o |-> busy_o); // R4

  AST_LOSS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$past(tx_en_o) && !$past(start_i)) |-> !tx_en_o); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_ADDR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_o) && $past(rsp_vld_i) && !$past(start_i) && busy_o)
      |-> (mem_addr_o == AW'($past(mem_addr_o) - 1'b1))); // R3

  AST_IDLE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(busy_o) && !$past(start_i)) |-> $stable(mem_addr_o)); // R13

  AST_RESET_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset_i |=> (!id_o && !ids_o)); // R12

endmodule

bind tree_arbiter tree_arbiter_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .rsp_vld_i   (rsp_vld_i),
  .cmd_reset_i (cmd_reset_i),
  .mem_addr_o  (mem_addr_o),
  .tx_en_o     (tx_en_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .id_o        (id_o),
  .ids_o       (ids_o)
);

// File: tb/tb_tree_arbiter.sv
`timescale 1ns/1ps
module tb_tree_arbiter;

  localparam int PRE = 8;

  logic       clk, rst_n;
  logic       start_i, kind_i, blk_sel_i, ptr_en_i;
  logic [1:0] mode_i;
  logic [7:0] ptr_i, len_i, mem_addr_o;
  logic       rsp_vld_i, rsp_bit_i, cmd_reset_i, mem_bit_i;
  logic       tx_en_o, tx_bit_o, busy_o, done_o, won_o, id_o, ids_o, presel_o;
  logic       mem [0:255];

  int checks = 0;
  int errs   = 0;
  logic exp_id = 0, exp_ids = 0, exp_pre = 0;

  tree_arbiter dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i), .mode_i(mode_i),
    .blk_sel_i(blk_sel_i), .ptr_en_i(ptr_en_i), .ptr_i(ptr_i), .len_i(len_i),
    .rsp_vld_i(rsp_vld_i), .rsp_bit_i(rsp_bit_i), .cmd_reset_i(cmd_reset_i),
    .mem_addr_o(mem_addr_o), .mem_bit_i(mem_bit_i), .tx_en_o(tx_en_o),
    .tx_bit_o(tx_bit_o), .busy_o(busy_o), .done_o(done_o), .won_o(won_o),
    .id_o(id_o), .ids_o(ids_o), .presel_o(presel_o)
  );

  assign mem_bit_i = mem[mem_addr_o];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_flags(input string req);
    chk(id_o == exp_id, req, "id_o", int'(id_o), int'(exp_id));
    chk(ids_o == exp_ids, req, "ids_o", int'(ids_o), int'(exp_ids));
    chk(presel_o == exp_pre, req, "presel_o", int'(presel_o), int'(exp_pre));
  endtask

  // Write a field MSB first at descending addresses starting at a.
  task automatic load_field(input int a, input int len, input int val);
    for (int j = 0; j < len; j++) mem[(a - j) & 255] = val[len-1-j];
  endtask

  function automatic logic model_in(input logic [1:0] m, input int tv, input int rv);
    case (m)
      2'd1:    return tv <= rv;
      2'd2:    return tv >= rv;
      default: return tv == rv;
    endcase
  endfunction

  // One full round; compares every bit against an independent prefix model.
  task automatic run_round(input logic kind, input logic [1:0] mode, input logic bsel,
                           input logic pen, input int ptr, input int len,
                           input int rval, input string req, output logic won);
    int s, tv, rv;
    logic in_run, rb;
    s = pen ? ptr : (bsel ? 71 : 103);
    @(negedge clk);
    start_i = 1; kind_i = kind; mode_i = mode; blk_sel_i = bsel;
    ptr_en_i = pen; ptr_i = 8'(ptr); len_i = 8'(len);
    @(negedge clk);
    start_i = 0;
    tv = 0; rv = 0; in_run = 1;
    for (int i = 0; i < PRE + len; i++) begin
      int a;
      a = (s - i) & 255;
      if (i == 0) chk(mem_addr_o == 8'(a), "R2", "start address", int'(mem_addr_o), a);
      else        chk(mem_addr_o == 8'(a), "R3", "address step", int'(mem_addr_o), a);
      chk(tx_bit_o == mem[a], "R4", "tx_bit_o", int'(tx_bit_o), int'(mem[a]));
      chk(busy_o == 1'b1, "R9", "busy during round", int'(busy_o), 1);
      if (i < PRE) chk(tx_en_o == 1'b1, "R5", "tx_en_o in preamble", int'(tx_en_o), 1);
      else         chk(tx_en_o == in_run, req, "tx_en_o contention", int'(tx_en_o), int'(in_run));
      if (i < PRE) rb = ~mem[a];
      else         rb = rval[len-1-(i-PRE)];
      rsp_vld_i = 1; rsp_bit_i = rb;
      if (i >= PRE) begin
        tv = tv * 2 + int'(mem[a]);
        rv = rv * 2 + int'(rb);
        in_run = model_in(mode, tv, rv);
      end
      @(negedge clk);
    end
    rsp_vld_i = 0;
    chk(done_o == 1'b1, "R9", "done_o pulse", int'(done_o), 1);
    chk(busy_o == 1'b0, "R9", "busy_o after round", int'(busy_o), 0);
    chk(won_o == in_run, req, "won_o", int'(won_o), int'(in_run));
    won = in_run;
    if (kind) exp_pre = in_run;
    else if (in_run) exp_id = 1;
    else exp_ids = 1;
    chk_flags(kind ? "R11" : "R10");
    @(negedge clk);
    chk(done_o == 1'b0, "R9", "done_o falls", int'(done_o), 0);
  endtask

  task automatic t_reset();
    chk(busy_o == 0 && done_o == 0 && tx_en_o == 0 && won_o == 0, "R1",
        "control outputs", int'({busy_o, done_o, tx_en_o, won_o}), 0);
    chk_flags("R1");
  endtask

  task automatic t_eq_win();
    logic w;
    load_field(95, 8, 'hA5);
    run_round(0, 2'd0, 0, 0, 0, 8, 'hA5, "R6", w);
    chk(w == 1, "R6", "equal field wins", int'(w), 1);
  endtask

  task automatic t_eq_lose();
    logic w;
    run_round(0, 2'd0, 0, 0, 0, 8, 'h85, "R6", w);
    chk(w == 0, "R6", "mid mismatch loses", int'(w), 0);
  endtask

  task automatic t_le_early();
    logic w;
    load_field(63, 8, 'h3C);
    run_round(1, 2'd1, 1, 0, 0, 8, 'h40, "R7", w);
    chk(w == 1, "R7", "first difference freezes win", int'(w), 1);
  endtask

  task automatic t_cmd_reset();
    @(negedge clk); cmd_reset_i = 1;
    @(negedge clk); cmd_reset_i = 0;
    exp_id = 0; exp_ids = 0;
    chk_flags("R12");
  endtask

  task automatic t_ge_wrap();
    logic w;
    load_field(251, 6, 'h2C);
    run_round(1, 2'd2, 0, 1, 3, 6, 'h30, "R8", w);
    chk(w == 0, "R8", "smaller field loses", int'(w), 0);
  endtask

  task automatic t_ge_tie();
    logic w;
    load_field(95, 8, 'h5A);
    run_round(1, 2'd2, 0, 0, 0, 8, 'h5A, "R8", w);
    chk(w == 1, "R8", "tie wins", int'(w), 1);
  endtask

  task automatic t_spare_mode();
    logic w;
    run_round(0, 2'd3, 0, 0, 0, 8, 'h5B, "R6", w);
    chk(w == 0, "R6", "code 3 acts as equality", int'(w), 0);
  endtask

  task automatic t_le_lose();
    logic w;
    load_field(95, 8, 'h81);
    run_round(0, 2'd1, 0, 0, 0, 8, 'h7F, "R7", w);
    chk(w == 0, "R7", "greater field loses", int'(w), 0);
  endtask

  task automatic t_idle_strobe();
    logic [7:0] a0;
    a0 = mem_addr_o;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); rsp_vld_i = 1; rsp_bit_i = k[0];
    end
    @(negedge clk); rsp_vld_i = 0;
    chk(mem_addr_o == a0, "R13", "address while idle", int'(mem_addr_o), int'(a0));
    chk(done_o == 0 && busy_o == 0, "R13", "no round from idle strobes",
        int'({done_o, busy_o}), 0);
    chk_flags("R13");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    checks++; errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = logic'(((i * 7) ^ (i >> 2)) & 1);
    start_i = 0; kind_i = 0; mode_i = 0; blk_sel_i = 0; ptr_en_i = 0;
    ptr_i = 0; len_i = 0; rsp_vld_i = 0; rsp_bit_i = 0; cmd_reset_i = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_eq_win();
    t_eq_lose();
    t_le_early();
    t_cmd_reset();
    t_ge_wrap();
    t_ge_tie();
    t_spare_mode();
    t_le_lose();
    t_idle_strobe();
    finish_run();
  end

endmodule